// File: doc/BRIEF.md
# Prioritised Channel Assignment Selector

This combinational block chooses one output channel out of eight. Each channel reports through its own flag whether it is free to take a new signal. A five-bit assignment code, made of a mandatory flag and a four-bit channel number, says which channel is wanted and how firmly. The block answers with a one-hot enable vector that names the chosen channel. The vector is all zero when no acceptable channel exists.

The code selects one of three policies. With the flag clear and channel number zero, the lowest-numbered free channel wins. With the flag clear and a channel number from 1 to 8, the search starts at that channel and moves upward. If nothing is free up to channel 8, the search wraps to channel 1 and ends just below the named one. With the flag set, only the named channel may be granted, and only when it is free. Codes outside these cases grant nothing.

Top module: `chanAssignSel`

## Requirements
- R1: At most one bit of `chanEnable` is high for any input combination.
- R2: A bit of `chanEnable` is high only if the matching bit of `chanFree` is high. Bit k of both vectors stands for channel k+1.
- R3: With `asgnCode` = 5'b00000, the enable goes to the lowest-numbered free channel.
- R4: With `asgnCode[4]` = 0 and `asgnCode[3:0]` = n (1 to 8), channel n is granted if it is free. Otherwise the first free channel above n is granted.
- R5: In the case of R4, when channels n to 8 are all busy, the search wraps and grants the lowest free channel among channels 1 to n-1.
- R6: With `asgnCode[4]` = 1 and `asgnCode[3:0]` = n (1 to 8), channel n is granted when it is free.
- R7: With `asgnCode[4]` = 1 and channel n busy, no enable is raised, even if other channels are free.
- R8: Channel numbers 9 to 15 with either flag value, and channel number 0 with the flag set, raise no enable.
- R9: When no channel is free, no enable is raised under any code.
- R10: The block holds no state. `chanEnable` depends only on the present values of `chanFree` and `asgnCode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| chanFree | input | 8 | Per-channel free flags. Bit k stands for channel k+1. |
| asgnCode | input | 5 | Bit 4 is the mandatory flag. Bits 3:0 hold the channel number (0 means none). |
| chanEnable | output | 8 | One-hot grant. Bit k enables channel k+1. All zero means no grant. |

## Verification
The block is purely combinational, so every result is due in the same cycle as the stimulus that causes it, with no register delay. The bench applies a new code and free pattern on the rising edge of its clock. It reads `chanEnable` at the falling edge half a period later, after the inputs have settled and well before they change again. Each vector therefore checks only the response to its own inputs: first a directed table, then an exhaustive sweep of all 32 codes against all 256 free patterns.

// File: rtl/chanSelPkg.sv
package chanSelPkg;
  localparam int NUM_CH = 8;
  localparam int IDX_W  = $clog2(NUM_CH);
  localparam int CODE_W = $clog2(NUM_CH + 1);

  typedef struct packed {
    logic             searchEn;
    logic             pickEn;
    logic [IDX_W-1:0] startIdx;
  } selCtrl_t;
endpackage

// File: rtl/chanSelCtrl.sv
module chanSelCtrl
  import chanSelPkg::*;
(
  input  logic [CODE_W:0] asgnCode,
  output selCtrl_t        ctrl
);
  logic [CODE_W-1:0] chanNum;
  logic              mandatory;
  logic              codeValid;

  always_comb begin
    chanNum   = asgnCode[CODE_W-1:0];
    mandatory = asgnCode[CODE_W];
    codeValid = (chanNum <= CODE_W'(NUM_CH)) && !(mandatory && (chanNum == '0));
    ctrl.searchEn = codeValid && !mandatory;
    ctrl.pickEn   = codeValid && mandatory;
    if (chanNum == '0) ctrl.startIdx = '0;
    else               ctrl.startIdx = IDX_W'(chanNum - CODE_W'(1));
  end
endmodule

// File: rtl/chanSelPath.sv
module chanSelPath
  import chanSelPkg::*;
(
  input  logic [NUM_CH-1:0] chanFree,
  input  selCtrl_t          ctrl,
  output logic [NUM_CH-1:0] grant
);
  logic [NUM_CH-1:0] rotFree;
  logic [NUM_CH-1:0] rotPick;
  logic [NUM_CH:0]   seenLower;
  logic [NUM_CH-1:0] searchGrant;
  logic [NUM_CH-1:0] pickGrant;

  function automatic logic [IDX_W-1:0] wrapIdx(input int pos);
    return IDX_W'(pos % NUM_CH);
  endfunction

  // bring the start channel to position 0
  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      rotFree[i] = chanFree[wrapIdx(i + int'(ctrl.startIdx))];
  end

  // lowest-set-bit chain over the rotated view
  assign seenLower[0] = 1'b0;
  for (genvar g = 0; g < NUM_CH; g++) begin : gPrio
    assign rotPick[g]     = rotFree[g] & ~seenLower[g];
    assign seenLower[g+1] = seenLower[g] | rotFree[g];
  end

  // rotate the pick back to channel order
  always_comb begin
    searchGrant = '0;
    for (int i = 0; i < NUM_CH; i++)
      searchGrant[wrapIdx(i + int'(ctrl.startIdx))] = rotPick[i];
  end

  assign pickGrant = chanFree & (NUM_CH'(1) << ctrl.startIdx);

  always_comb begin
    if (ctrl.searchEn)    grant = searchGrant;
    else if (ctrl.pickEn) grant = pickGrant;
    else                  grant = '0;
  end

  always_comb begin
    if (!$isunknown({chanFree, ctrl})) begin
      if (ctrl.searchEn && (chanFree != '0))
        AST_SEARCH_FINDS: assert (grant != '0) else $error("search missed a free channel"); // R4
      if (ctrl.pickEn)
        AST_PICK_NAMED_ONLY: assert ((grant & ~(NUM_CH'(1) << ctrl.startIdx)) == '0) else $error("mandatory grant off target"); // R7
    end
  end
endmodule

// File: rtl/chanAssignSel.sv
module chanAssignSel
  import chanSelPkg::*;
(
  input  logic [NUM_CH-1:0] chanFree,
  input  logic [CODE_W:0]   asgnCode,
  output logic [NUM_CH-1:0] chanEnable
);
  selCtrl_t selCtrl;

  chanSelCtrl u_ctrl (
    .asgnCode (asgnCode),
    .ctrl     (selCtrl)
  );

  chanSelPath u_path (
    .chanFree (chanFree),
    .ctrl     (selCtrl),
    .grant    (chanEnable)
  );

  always_comb begin
    if (!$isunknown({chanFree, asgnCode})) begin
      AST_AT_MOST_ONE: assert ($onehot0(chanEnable)) else $error("multiple enables"); // R1
      AST_ONLY_FREE: assert ((chanEnable & ~chanFree) == '0) else $error("busy channel enabled"); // R2
      if ((asgnCode[CODE_W-1:0] > CODE_W'(NUM_CH)) || (asgnCode[CODE_W] && asgnCode[CODE_W-1:0] == '0))
        AST_INVALID_QUIET: assert (chanEnable == '0) else $error("invalid code granted"); // R8
      if (chanFree == '0)
        AST_NONE_FREE: assert (chanEnable == '0) else $error("grant with nothing free"); // R9
    end
  end
endmodule

// File: tb/chanAssignSel_bench.sv
module chanAssignSel_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] chanFree;
  logic [4:0] asgnCode;
  logic [7:0] chanEnable;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chanAssignSel u_chanAssignSel (
    .chanFree   (chanFree),
    .asgnCode   (asgnCode),
    .chanEnable (chanEnable)
  );

  // {req, code, free, expected}
  localparam logic [24:0] VEC [16] = '{
    {4'd9, 5'b00000, 8'b0000_0000, 8'b0000_0000},
    {4'd3, 5'b00000, 8'b1111_1111, 8'b0000_0001},
    {4'd3, 5'b00000, 8'b1010_0000, 8'b0010_0000},
    {4'd4, 5'b00011, 8'b1111_1111, 8'b0000_0100},
    {4'd4, 5'b00011, 8'b1000_0001, 8'b1000_0000},
    {4'd5, 5'b00110, 8'b0000_0110, 8'b0000_0010},
    {4'd4, 5'b01000, 8'b1000_0000, 8'b1000_0000},
    {4'd5, 5'b01000, 8'b0000_0001, 8'b0000_0001},
    {4'd6, 5'b10101, 8'b0001_0000, 8'b0001_0000},
    {4'd7, 5'b10101, 8'b1110_1111, 8'b0000_0000},
    {4'd6, 5'b11000, 8'b1111_1111, 8'b1000_0000},
    {4'd8, 5'b01001, 8'b1111_1111, 8'b0000_0000},
    {4'd8, 5'b01111, 8'b1111_1111, 8'b0000_0000},
    {4'd8, 5'b10000, 8'b1111_1111, 8'b0000_0000},
    {4'd8, 5'b11001, 8'b1111_1111, 8'b0000_0000},
    {4'd9, 5'b00001, 8'b0000_0000, 8'b0000_0000}
  };

  function automatic logic [7:0] modelSel(input logic [4:0] code, input logic [7:0] free);
    int n;
    int start;
    n = int'(code[3:0]);
    if (n > 8 || (code[4] && n == 0)) return 8'h00;
    if (code[4]) return free[n-1] ? (8'h01 << (n-1)) : 8'h00;
    start = (n == 0) ? 0 : n - 1;
    for (int k = 0; k < 8; k++)
      if (free[(start + k) % 8]) return 8'h01 << ((start + k) % 8);
    return 8'h00;
  endfunction

  function automatic string reqOf(input logic [4:0] code, input logic [7:0] free, input logic [7:0] exp);
    int n;
    n = int'(code[3:0]);
    if (n > 8 || (code[4] && n == 0)) return "R8";
    if (free == 8'h00) return "R9";
    if (code[4]) return (exp != 0) ? "R6" : "R7";
    if (n == 0) return "R3";
    if ((exp & ~(8'hFF << (n-1))) != 0) return "R5";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s code=%b free=%b actual=%b expected=%b", req, asgnCode, chanFree, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] code, input logic [7:0] free);
    @(posedge clk);
    asgnCode = code;
    chanFree = free;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    chanFree = '0;
    asgnCode = '0;
    @(negedge clk);
    check("R9", chanEnable, 8'h00);  // idle state, nothing free

    for (int v = 0; v < 16; v++) begin
      apply(VEC[v][20:16], VEC[v][15:8]);
      check($sformatf("R%0d", VEC[v][24:21]), chanEnable, VEC[v][7:0]);
    end

    // R10: same inputs after other traffic give the same answer
    apply(5'b00110, 8'b0000_0110);
    check("R10", chanEnable, 8'b0000_0010);
    apply(5'b00000, 8'b1000_0000);
    check("R10", chanEnable, 8'b1000_0000);
    apply(5'b00110, 8'b0000_0110);
    check("R10", chanEnable, 8'b0000_0010);

    for (int c = 0; c < 32; c++) begin
      for (int f = 0; f < 256; f++) begin
        logic [7:0] exp;
        apply(5'(c), 8'(f));
        exp = modelSel(5'(c), 8'(f));
        check(reqOf(5'(c), 8'(f), exp), chanEnable, exp);
        check("R1", 8'($onehot0(chanEnable)), 8'h01);
        check("R2", chanEnable & ~chanFree, 8'h00);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule